// File: doc/BRIEF.md
# Bit-Parallel Polynomial-Basis Galois Field Multiplier

This block multiplies two elements of GF(2^M) written in polynomial basis and returns their product reduced modulo a monic irreducible polynomial of degree M. Every operand bit i holds the coefficient of x^i. Coefficient addition is XOR and coefficient multiplication is AND. The polynomial is fixed at elaboration through a parameter. That parameter holds its M low-order coefficients, and the x^M term is implied.

The product is built in two stages, with no iteration. A lower inner-product network forms the M low coefficients of the unreduced product. An upper inner-product network forms its M-1 high coefficients, for x^M through x^(2M-2). A fold network then adds each high coefficient back into the low word along a row that depends only on the polynomial. The rows are computed at elaboration, and row k is x^(M+k) mod P(x).

An output stage closes the datapath, and a parameter selects its form. In the registered form it is one register with a valid flag. In the pass-through form it is plain wiring. The block has no other state.

Top module: `gf2m_pb_mult`

## Requirements
- R1: For every pair of operands, `prod` equals a·b mod P(x), where bit i of each word is the coefficient of x^i and P(x) = x^M + sum of POLY[i]·x^i.
- R2: When deg(a) + deg(b) < M, no reduction takes place, and `prod` equals the carry-less product of the operands.
- R3: The operands a = x^(M-1) and b = x give `prod` = POLY, which is x^M mod P(x).
- R4: For M = 3 and POLY = 3'b011 the outputs are c0 = d0^e0, c1 = d1^e0^e1 and c2 = d2^e1. Here d0 = a0b0, d1 = a0b1^a1b0, d2 = a0b2^a1b1^a2b0, e0 = a1b2^a2b1 and e1 = a2b2.
- R5: If either operand is zero, `prod` is zero.
- R6: If b = 1 (only bit 0 set), `prod` equals a.
- R7: The product is commutative: swapping a and b leaves `prod` unchanged.
- R8: With OUT_REG = 1, `out_valid` is `in_valid` delayed by one clock. The product of operands sampled with `in_valid` high appears on `prod` one clock later.
- R9: With OUT_REG = 1, while `in_valid` is low, `prod` holds its value whatever the operands do.
- R10: With OUT_REG = 1, while `rst_n` is low, `out_valid` and `prod` are zero.
- R11: With OUT_REG = 0, `prod` follows the operands in the same cycle and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| in_valid | input | 1 | Operands on `a_op`/`b_op` are to be multiplied |
| a_op | input | M | First operand, bit i = coefficient of x^i |
| b_op | input | M | Second operand, bit i = coefficient of x^i |
| out_valid | output | 1 | `prod` carries a new product |
| prod | output | M | Reduced product a·b mod P(x) |

## Verification
The bench builds two copies of the block. The first uses M = 8 with POLY = 8'h1B and the output register on. Sweeping all 65,536 operand pairs through it exercises every fold row, the latency and the hold-while-idle behaviour against a shift-and-XOR reference. The second uses M = 3 with POLY = 3'b011 and the register off. An exhaustive sweep of it checks the closed-form coefficient equations, commutativity over the whole table and the same-cycle pass-through.

// File: rtl/gf2m_pb_pkg.sv
package gf2m_pb_pkg;

    localparam int GF_MAX_M = 32;

    typedef logic [GF_MAX_M-1:0] gf_word_t;

    // Mask keeping the low m coefficient positions
    function automatic gf_word_t gf_mask(int unsigned m);
        gf_word_t msk;
        msk = '0;
        for (int i = 0; i < GF_MAX_M; i++) begin
            if (i < m) msk[i] = 1'b1;
        end
        return msk;
    endfunction

    // Fold row k: x^(m+k) reduced modulo x^m + poly_low
    function automatic gf_word_t gf_fold_row(int unsigned m, gf_word_t poly_low, int unsigned k);
        gf_word_t row;
        gf_word_t msk;
        logic     top;
        msk = gf_mask(m);
        row = poly_low & msk;
        for (int unsigned s = 0; s < k; s++) begin
            top = row[m-1];
            row = (row << 1) & msk;
            if (top) row = row ^ (poly_low & msk);
        end
        return row;
    endfunction

endpackage

// File: rtl/gf2m_low_net.sv
module gf2m_low_net #(
    parameter int M = 8
) (
    input  logic [M-1:0] a_vec,
    input  logic [M-1:0] b_vec,
    output logic [M-1:0] lo_vec
);
    // lo_vec[k] = XOR of a[i]&b[k-i], i = 0..k  (lower-triangular product)
    for (genvar k = 0; k < M; k++) begin : g_lo
        always_comb begin
            lo_vec[k] = 1'b0;
            for (int i = 0; i <= k; i++) begin
                lo_vec[k] = lo_vec[k] ^ (a_vec[i] & b_vec[k-i]);
            end
        end
    end
endmodule

// File: rtl/gf2m_high_net.sv
module gf2m_high_net #(
    parameter int M = 8
) (
    input  logic [M-1:0] a_vec,
    input  logic [M-1:0] b_vec,
    output logic [M-2:0] hi_vec
);
    // hi_vec[k] = XOR of a[i]&b[M+k-i], i = k+1..M-1  (upper-triangular product)
    for (genvar k = 0; k < M - 1; k++) begin : g_hi
        always_comb begin
            hi_vec[k] = 1'b0;
            for (int i = k + 1; i < M; i++) begin
                hi_vec[k] = hi_vec[k] ^ (a_vec[i] & b_vec[M+k-i]);
            end
        end
    end
endmodule

// File: rtl/gf2m_fold.sv
module gf2m_fold
    import gf2m_pb_pkg::*;
#(
    parameter int           M    = 8,
    parameter logic [M-1:0] POLY = 8'h1B
) (
    input  logic [M-1:0] lo_vec,
    input  logic [M-2:0] hi_vec,
    output logic [M-1:0] res_vec
);
    localparam gf_word_t POLY_W = gf_word_t'(POLY);

    // Column j of the fold matrix: which high coefficients land on x^j
    function automatic logic [M-2:0] fold_column(int unsigned j);
        logic [M-2:0] col;
        gf_word_t     row;
        for (int unsigned k = 0; k < M - 1; k++) begin
            row    = gf_fold_row(M, POLY_W, k);
            col[k] = row[j];
        end
        return col;
    endfunction

    for (genvar j = 0; j < M; j++) begin : g_col
        localparam logic [M-2:0] COL = fold_column(j);
        assign res_vec[j] = lo_vec[j] ^ (^(hi_vec & COL));
    end
endmodule

// File: rtl/gf2m_out_stage.sv
module gf2m_out_stage #(
    parameter int M       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] res_vec,
    output logic         out_valid,
    output logic [M-1:0] prod
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                prod      <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) prod <= res_vec;
            end
        end
    end else begin : g_wire
        assign out_valid = in_valid;
        assign prod      = res_vec;
    end
endmodule

// File: rtl/gf2m_pb_mult.sv
module gf2m_pb_mult #(
    parameter int           M       = 8,
    parameter logic [M-1:0] POLY    = 8'h1B,
    parameter bit           OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] a_op,
    input  logic [M-1:0] b_op,
    output logic         out_valid,
    output logic [M-1:0] prod
);
    logic [M-1:0] lo_vec;
    logic [M-2:0] hi_vec;
    logic [M-1:0] res_vec;

    gf2m_low_net #(.M(M)) u_low (
        .a_vec  (a_op),
        .b_vec  (b_op),
        .lo_vec (lo_vec)
    );

    gf2m_high_net #(.M(M)) u_high (
        .a_vec  (a_op),
        .b_vec  (b_op),
        .hi_vec (hi_vec)
    );

    gf2m_fold #(.M(M), .POLY(POLY)) u_fold (
        .lo_vec  (lo_vec),
        .hi_vec  (hi_vec),
        .res_vec (res_vec)
    );

    gf2m_out_stage #(.M(M), .OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .res_vec   (res_vec),
        .out_valid (out_valid),
        .prod      (prod)
    );
endmodule

// File: rtl/gf2m_pb_mult_chk.sv
module gf2m_pb_mult_chk #(
    parameter int           M       = 8,
    parameter logic [M-1:0] POLY    = 8'h1B,
    parameter bit           OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] a_op,
    input logic [M-1:0] b_op,
    input logic         out_valid,
    input logic [M-1:0] prod
);
    localparam logic [M-1:0] ONE_W = 1;
    localparam logic [M-1:0] X_W   = 2;
    localparam logic [M-1:0] TOP_W = ONE_W << (M - 1);

    if (OUT_REG) begin : g_reg
        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> out_valid == $past(in_valid)); // R8
        AST_ZERO_ANNIHILATES: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (a_op == '0 || b_op == '0) |=> prod == '0); // R5
        AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && b_op == ONE_W |=> prod == $past(a_op)); // R6
        AST_TOP_TIMES_X: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && a_op == TOP_W && b_op == X_W |=> prod == POLY); // R3
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(prod)); // R9
    end else begin : g_wire
        AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid); // R11
        AST_ZERO_ANNIHILATES: assert property (@(posedge clk) disable iff (!rst_n)
            (a_op == '0 || b_op == '0) |-> prod == '0); // R5
        AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
            b_op == ONE_W |-> prod == a_op); // R6
        AST_TOP_TIMES_X: assert property (@(posedge clk) disable iff (!rst_n)
            a_op == TOP_W && b_op == X_W |-> prod == POLY); // R3
    end
endmodule

bind gf2m_pb_mult gf2m_pb_mult_chk #(.M(M), .POLY(POLY), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_op      (a_op),
    .b_op      (b_op),
    .out_valid (out_valid),
    .prod      (prod)
);

// File: tb/gf2m_pb_mult_bench.sv
module gf2m_pb_mult_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v8 = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic       ov8;
    logic [7:0] p8;
    logic       v3 = 1'b0;
    logic [2:0] a3 = '0, b3 = '0;
    logic       ov3;
    logic [2:0] p3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    gf2m_pb_mult #(.M(8), .POLY(8'h1B), .OUT_REG(1'b1)) u_gf2m_pb_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .a_op(a8), .b_op(b8),
        .out_valid(ov8), .prod(p8)
    );

    gf2m_pb_mult #(.M(3), .POLY(3'b011), .OUT_REG(1'b0)) u_gf2m_pb_mult_small (
        .clk(clk), .rst_n(rst_n), .in_valid(v3), .a_op(a3), .b_op(b3),
        .out_valid(ov3), .prod(p3)
    );

    function automatic logic [7:0] ref_mul8(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc = '0;
        logic [7:0] sh = a;
        logic       top;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= sh;
            top = sh[7];
            sh  = sh << 1;
            if (top) sh ^= 8'h1B;
        end
        return acc;
    endfunction

    function automatic int deg8(logic [7:0] x);
        int d = -1;
        for (int i = 0; i < 8; i++) if (x[i]) d = i;
        return d;
    endfunction

    function automatic logic [14:0] clmul8(logic [7:0] a, logic [7:0] b);
        logic [14:0] acc = '0;
        for (int i = 0; i < 8; i++) if (b[i]) acc ^= (15'(a) << i);
        return acc;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] tbl [64];
        logic [7:0] exp_prev;
        logic [7:0] held;
        string      tag_prev;
        bit         have_prev;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", {31'd0, ov8}, 32'd0);
        check("R10", {24'd0, p8}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", {31'd0, ov8}, 32'd0);

        // Small configuration, exhaustive, same-cycle
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [2:0] aa, bb, c;
                logic d0, d1, d2, e0, e1;
                aa = 3'(a); bb = 3'(b);
                @(negedge clk);
                a3 = aa; b3 = bb; v3 = (a + b) % 2 == 0;
                #1;
                d0 = aa[0] & bb[0];
                d1 = (aa[0] & bb[1]) ^ (aa[1] & bb[0]);
                d2 = (aa[0] & bb[2]) ^ (aa[1] & bb[1]) ^ (aa[2] & bb[0]);
                e0 = (aa[1] & bb[2]) ^ (aa[2] & bb[1]);
                e1 = aa[2] & bb[2];
                c  = {d2 ^ e1, d1 ^ e0 ^ e1, d0 ^ e0};
                check("R4", {29'd0, p3}, {29'd0, c});
                check("R11", {31'd0, ov3}, {31'd0, v3});
                tbl[a*8+b] = p3;
            end
        end
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                check("R7", {29'd0, tbl[a*8+b]}, {29'd0, tbl[b*8+a]});
        @(negedge clk);
        a3 = 3'b100; b3 = 3'b010; #1;
        check("R3", {29'd0, p3}, 32'd3);

        // Registered configuration, exhaustive sweep
        have_prev = 1'b0;
        exp_prev  = '0;
        tag_prev  = "";
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [7:0] aa, bb;
                aa = 8'(a); bb = 8'(b);
                @(negedge clk);
                if (have_prev) begin
                    check(tag_prev, {24'd0, p8}, {24'd0, exp_prev});
                    check("R8", {31'd0, ov8}, 32'd1);
                end
                a8 = aa; b8 = bb; v8 = 1'b1;
                if (aa == 0 || bb == 0) begin
                    tag_prev = "R5"; exp_prev = 8'h00;
                end else if (bb == 8'h01) begin
                    tag_prev = "R6"; exp_prev = aa;
                end else if (deg8(aa) + deg8(bb) < 8) begin
                    tag_prev = "R2"; exp_prev = clmul8(aa, bb)[7:0];
                end else begin
                    tag_prev = "R1"; exp_prev = ref_mul8(aa, bb);
                end
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check(tag_prev, {24'd0, p8}, {24'd0, exp_prev});

        // R3: x^7 * x = x^8 mod P
        a8 = 8'h80; b8 = 8'h02; v8 = 1'b1;
        @(negedge clk);
        check("R3", {24'd0, p8}, 32'h1B);
        a8 = 8'h57; b8 = 8'h83;
        @(negedge clk);
        check("R1", {24'd0, p8}, 32'hC1);
        held = p8;

        // R9: idle cycles with changing operands hold the product
        v8 = 1'b0;
        for (int i = 0; i < 6; i++) begin
            a8 = 8'(i * 37 + 5); b8 = 8'(i * 91 + 3);
            @(negedge clk);
            check("R9", {24'd0, p8}, {24'd0, held});
            check("R8", {31'd0, ov8}, 32'd0);
        end

        // R10: reset in mid-run clears the register
        rst_n = 1'b0;
        #1;
        check("R10", {24'd0, p8}, 32'd0);
        check("R10", {31'd0, ov8}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule